// File: doc/BRIEF.md
# Fault Detection and Rollback Controller

This controller supervises a set of replaceable functional units that execute instructions together. For each accepted instruction it keeps a private copy of the instruction word. From that copy it derives which units must report completion and which units may drive the bus. It sends a one-cycle synchronisation pulse to the participating units. It then watches their Complete, Active and internal-fault lines and the error lines of the bus checkers, until every expected unit has completed or a fault is found.

Any fault makes the controller request a rollback to an address that software loads into the rollback-point register. The retry itself corrects a transient fault. Each unit carries a flag that records a fault since the last clean completion. If a flagged unit faults again, the controller toggles that unit's power switch to bring in a spare. It waits a bounded time for the switch status to change, and then rolls back. A momentary system-wide disturbance starts a fixed restart sequence instead: all units are held in reset for a set number of cycles, and then the controller rolls back.

Top module: `rbc_top`

## Requirements
- R1: After reset, `ready` is 1 and `syncOut`, `unitRst`, `swToggle`, `rollbackReq`, `instrDone` and `replaceFail` are all 0.
- R2: The instruction word holds the expected-Complete mask in bits [NUM_UNITS-1:0] and the allowed-Active mask in bits [2*NUM_UNITS-1:NUM_UNITS]. In the cycle after an instruction is accepted, `syncOut` equals the Complete mask for exactly one cycle.
- R3: Once every unit in the Complete mask has raised Complete, in any order and over any number of cycles, with no fault, `instrDone` pulses for one cycle and `ready` returns.
- R4: A fault is recorded in three cases: a unit raises its internal-fault line, a unit outside the Active mask raises Active, or a unit outside the Complete mask raises Complete. A fault has priority over completion in the same cycle.
- R5: A checker error is a fault charged to the lowest-numbered unit in the Active mask. With an empty Active mask the fault is charged to no unit: it rolls back every time and never replaces a unit.
- R6: If the Complete mask is not satisfied after CPL_TIMEOUT cycles of execution, the units still missing are charged with a fault. The rollback request appears CPL_TIMEOUT cycles after the first execution cycle.
- R7: A fault on a unit with no earlier flag sets that unit's flag. It then produces a one-cycle `rollbackReq` with `unitRst` all ones, after which `ready` returns.
- R8: `rbLoad` loads `rbAddrIn` into the rollback-point register in any state, and `rollAddr` shows that register.
- R9: A fault on a unit that is already flagged produces a one-hot `swToggle` pulse on the lowest such unit. A rollback follows once that unit's switch status changes, and the unit's flag is then cleared.
- R10: A clean completion clears every flag, so a unit that faulted before it is only rolled back on its next fault.
- R11: If the switch status does not change within SW_WAIT cycles after the toggle, `replaceFail` is set and stays set, and the rollback still follows.
- R12: A `powerGlitch` pulse holds `unitRst` all ones for RST_CYC cycles, clears all flags and then issues a rollback.
- R13: `instrValid` is ignored while `ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instrValid | input | 1 | New instruction offered |
| instrWord | input | 2*NUM_UNITS | Allowed-Active mask (high half) and expected-Complete mask (low half) |
| ready | output | 1 | Controller idle, instruction will be accepted |
| rbLoad | input | 1 | Load rollback-point register |
| rbAddrIn | input | ADDR_W | Rollback-point address from the program |
| powerGlitch | input | 1 | System-wide transient event, starts restart |
| unitComplete | input | NUM_UNITS | Per-unit Complete lines |
| unitActive | input | NUM_UNITS | Per-unit Active lines |
| unitFault | input | NUM_UNITS | Per-unit internal-fault lines |
| chkErr | input | NUM_CHK | Bus checker error lines |
| swStatus | input | NUM_UNITS | Power-switch position readback |
| syncOut | output | NUM_UNITS | Per-unit synchronisation pulse |
| unitRst | output | NUM_UNITS | Per-unit reset to standard state |
| swToggle | output | NUM_UNITS | Per-unit power-switch toggle command |
| rollbackReq | output | 1 | Restart execution at `rollAddr` |
| rollAddr | output | ADDR_W | Current rollback point |
| instrDone | output | 1 | Instruction completed cleanly |
| replaceFail | output | 1 | Sticky: a switch did not respond |

## Verification
The bench builds the controller with four units, two checkers, CPL_TIMEOUT of 12, SW_WAIT of 6 and RST_CYC of 4. These short windows let a completion timeout, a switch that never moves and a full restart each finish within a few dozen cycles, so the bench can count their exact lengths. With four units, faults from different sources can be charged to different units. This shows that retry-versus-replace is decided per unit, and that checker errors follow the Active mask.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_RUN,
    ST_DONE,
    ST_SWAP_CMD,
    ST_SWAP_WAIT,
    ST_RESTART,
    ST_ROLL
  } rbc_state_e;

  // control -> datapath strobes
  typedef struct packed {
    logic loadInstr;
    logic syncEn;
    logic clrRun;
    logic runCount;
    logic mergeFlags;
    logic clrFlags;
    logic startSwap;
    logic togEn;
    logic swapOk;
    logic swapFail;
    logic clrWait;
    logic waitCount;
    logic clrRst;
    logic rstCount;
  } rbc_strobe_t;

endpackage

// File: rtl/rbc_datapath.sv
module rbc_datapath
  import rbc_pkg::*;
#(
  parameter int NUM_UNITS   = 4,
  parameter int NUM_CHK     = 2,
  parameter int ADDR_W      = 12,
  parameter int CPL_TIMEOUT = 12,
  parameter int SW_WAIT     = 6,
  parameter int RST_CYC     = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  rbc_strobe_t            strb,
  input  logic [2*NUM_UNITS-1:0] instrWord,
  input  logic                   rbLoad,
  input  logic [ADDR_W-1:0]      rbAddrIn,
  input  logic [NUM_UNITS-1:0]   unitComplete,
  input  logic [NUM_UNITS-1:0]   unitActive,
  input  logic [NUM_UNITS-1:0]   unitFault,
  input  logic [NUM_CHK-1:0]     chkErr,
  input  logic [NUM_UNITS-1:0]   swStatus,
  output logic                   dpFault,
  output logic                   dpRepeat,
  output logic                   dpDone,
  output logic                   swChanged,
  output logic                   swExpired,
  output logic                   rstExpired,
  output logic [NUM_UNITS-1:0]   syncOut,
  output logic [NUM_UNITS-1:0]   swToggle,
  output logic [ADDR_W-1:0]      rollAddr,
  output logic                   replaceFail
);

  localparam int IW = 2 * NUM_UNITS;
  localparam int UW = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;
  localparam int TW = $clog2(CPL_TIMEOUT + 1);
  localparam int WW = $clog2(SW_WAIT + 1);
  localparam int RW = $clog2(RST_CYC + 1);
  localparam logic [TW-1:0] T_LAST = TW'(CPL_TIMEOUT - 1);
  localparam logic [WW-1:0] W_LAST = WW'(SW_WAIT - 1);
  localparam logic [RW-1:0] R_LAST = RW'(RST_CYC - 1);

  logic [IW-1:0]        instrReg;
  logic [ADDR_W-1:0]    rbReg;
  logic [NUM_UNITS-1:0] seenReg;
  logic [NUM_UNITS-1:0] flags;
  logic [TW-1:0]        runCnt;
  logic [WW-1:0]        waitCnt;
  logic [RW-1:0]        rstCnt;
  logic [UW-1:0]        swapIdx;
  logic                 swSnap;
  logic                 failReg;

  logic [NUM_UNITS-1:0] cplMask, actMask;
  logic [NUM_UNITS-1:0] cplSoFar, missing, chkVec, faultVec, repeatVec;
  logic                 chkHit, unattr, cplNow, timeoutHit;
  logic [UW-1:0]        nextIdx;

  function automatic logic [UW-1:0] firstIdx(input logic [NUM_UNITS-1:0] v);
    logic [UW-1:0] idx;
    idx = '0;
    for (int i = NUM_UNITS - 1; i >= 0; i--) begin
      if (v[i]) idx = UW'(i);
    end
    return idx;
  endfunction

  function automatic logic [NUM_UNITS-1:0] idxMask(input logic [UW-1:0] idx);
    logic [NUM_UNITS-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (idx == UW'(i)) m[i] = 1'b1;
    end
    return m;
  endfunction

  assign cplMask  = instrReg[NUM_UNITS-1:0];
  assign actMask  = instrReg[IW-1:NUM_UNITS];
  assign cplSoFar = (seenReg | unitComplete) & cplMask;
  assign cplNow   = (cplSoFar == cplMask);
  assign missing  = cplMask & ~cplSoFar;

  assign chkHit = |chkErr;
  assign unattr = chkHit && (actMask == '0);
  assign chkVec = (chkHit && !unattr) ? idxMask(firstIdx(actMask)) : '0;

  assign timeoutHit = (runCnt == T_LAST) && !cplNow;

  assign faultVec = unitFault
                  | (unitActive & ~actMask)
                  | (unitComplete & ~cplMask)
                  | chkVec
                  | (timeoutHit ? missing : '0);

  assign repeatVec = faultVec & flags;
  assign nextIdx   = firstIdx(repeatVec);

  assign dpFault    = (|faultVec) || unattr;
  assign dpRepeat   = |repeatVec;
  assign dpDone     = cplNow;
  assign swChanged  = (swStatus[swapIdx] != swSnap);
  assign swExpired  = (waitCnt == W_LAST);
  assign rstExpired = (rstCnt == R_LAST);

  assign syncOut     = strb.syncEn ? cplMask : '0;
  assign swToggle    = strb.togEn ? idxMask(swapIdx) : '0;
  assign rollAddr    = rbReg;
  assign replaceFail = failReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      instrReg <= '0;
      rbReg    <= '0;
    end else begin
      if (strb.loadInstr) instrReg <= instrWord;
      if (rbLoad)         rbReg    <= rbAddrIn;
    end
  end

  // completion tracking and execution timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenReg <= '0;
      runCnt  <= '0;
    end else if (strb.clrRun) begin
      seenReg <= '0;
      runCnt  <= '0;
    end else if (strb.runCount) begin
      seenReg <= seenReg | (unitComplete & cplMask);
      if (runCnt != T_LAST) runCnt <= runCnt + 1'b1;
    end
  end

  // per-unit "faulted since last clean completion" flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= '0;
    end else if (strb.clrFlags) begin
      flags <= '0;
    end else if (strb.mergeFlags) begin
      flags <= flags | faultVec;
    end else if (strb.swapOk) begin
      flags <= flags & ~idxMask(swapIdx);
    end
  end

  // power-switch replacement
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swapIdx <= '0;
      swSnap  <= 1'b0;
      waitCnt <= '0;
      failReg <= 1'b0;
    end else begin
      if (strb.startSwap) begin
        swapIdx <= nextIdx;
        swSnap  <= swStatus[nextIdx];
      end
      if (strb.clrWait) waitCnt <= '0;
      else if (strb.waitCount && waitCnt != W_LAST) waitCnt <= waitCnt + 1'b1;
      if (strb.swapFail) failReg <= 1'b1;
    end
  end

  // restart hold timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstCnt <= '0;
    else if (strb.clrRst) rstCnt <= '0;
    else if (strb.rstCount && rstCnt != R_LAST) rstCnt <= rstCnt + 1'b1;
  end

  // R9
  one_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(swToggle));

  // R6
  run_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.runCount |-> (runCnt <= T_LAST));

  // R11
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    failReg |=> failReg);

endmodule

// File: rtl/rbc_ctrl.sv
module rbc_ctrl
  import rbc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrValid,
  input  logic        powerGlitch,
  input  logic        dpFault,
  input  logic        dpRepeat,
  input  logic        dpDone,
  input  logic        swChanged,
  input  logic        swExpired,
  input  logic        rstExpired,
  output rbc_strobe_t strb,
  output logic        ready,
  output logic        instrDone,
  output logic        rollbackReq,
  output logic        rstAll
);

  rbc_state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    strb.syncEn = (state == ST_SYNC);
    strb.togEn  = (state == ST_SWAP_CMD);
    case (state)
      ST_IDLE: begin
        if (instrValid) begin
          strb.loadInstr = 1'b1;
          nextState = ST_SYNC;
        end
      end
      ST_SYNC: begin
        strb.clrRun = 1'b1;
        nextState = ST_RUN;
      end
      ST_RUN: begin
        strb.runCount = 1'b1;
        if (dpFault) begin
          strb.mergeFlags = 1'b1;
          if (dpRepeat) begin
            strb.startSwap = 1'b1;
            nextState = ST_SWAP_CMD;
          end else begin
            nextState = ST_ROLL;
          end
        end else if (dpDone) begin
          strb.clrFlags = 1'b1;
          nextState = ST_DONE;
        end
      end
      ST_DONE:     nextState = ST_IDLE;
      ST_SWAP_CMD: begin
        strb.clrWait = 1'b1;
        nextState = ST_SWAP_WAIT;
      end
      ST_SWAP_WAIT: begin
        strb.waitCount = 1'b1;
        if (swChanged) begin
          strb.swapOk = 1'b1;
          nextState = ST_ROLL;
        end else if (swExpired) begin
          strb.swapFail = 1'b1;
          nextState = ST_ROLL;
        end
      end
      ST_RESTART: begin
        strb.rstCount = 1'b1;
        if (rstExpired) nextState = ST_ROLL;
      end
      ST_ROLL:  nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
    // a system-wide transient overrides any sequence in progress
    if (powerGlitch) begin
      strb.loadInstr  = 1'b0;
      strb.mergeFlags = 1'b0;
      strb.startSwap  = 1'b0;
      strb.swapOk     = 1'b0;
      strb.swapFail   = 1'b0;
      strb.clrRst     = 1'b1;
      strb.clrFlags   = 1'b1;
      nextState = ST_RESTART;
    end
  end

  assign ready       = (state == ST_IDLE);
  assign instrDone   = (state == ST_DONE);
  assign rollbackReq = (state == ST_ROLL);
  assign rstAll      = (state == ST_ROLL) || (state == ST_RESTART);

  // R2
  sync_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.syncEn |=> !strb.syncEn);

  // R7
  roll_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rollbackReq && !powerGlitch) |=> ready);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrDone && !powerGlitch) |=> ready);

endmodule

// File: rtl/rbc_top.sv
module rbc_top
  import rbc_pkg::*;
#(
  parameter int NUM_UNITS   = 4,
  parameter int NUM_CHK     = 2,
  parameter int ADDR_W      = 12,
  parameter int CPL_TIMEOUT = 12,
  parameter int SW_WAIT     = 6,
  parameter int RST_CYC     = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   instrValid,
  input  logic [2*NUM_UNITS-1:0] instrWord,
  output logic                   ready,
  input  logic                   rbLoad,
  input  logic [ADDR_W-1:0]      rbAddrIn,
  input  logic                   powerGlitch,
  input  logic [NUM_UNITS-1:0]   unitComplete,
  input  logic [NUM_UNITS-1:0]   unitActive,
  input  logic [NUM_UNITS-1:0]   unitFault,
  input  logic [NUM_CHK-1:0]     chkErr,
  input  logic [NUM_UNITS-1:0]   swStatus,
  output logic [NUM_UNITS-1:0]   syncOut,
  output logic [NUM_UNITS-1:0]   unitRst,
  output logic [NUM_UNITS-1:0]   swToggle,
  output logic                   rollbackReq,
  output logic [ADDR_W-1:0]      rollAddr,
  output logic                   instrDone,
  output logic                   replaceFail
);

  rbc_strobe_t strb;
  logic dpFault, dpRepeat, dpDone, swChanged, swExpired, rstExpired, rstAll;

  rbc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .powerGlitch(powerGlitch),
    .dpFault(dpFault), .dpRepeat(dpRepeat), .dpDone(dpDone),
    .swChanged(swChanged), .swExpired(swExpired), .rstExpired(rstExpired),
    .strb(strb), .ready(ready), .instrDone(instrDone),
    .rollbackReq(rollbackReq), .rstAll(rstAll)
  );

  rbc_datapath #(
    .NUM_UNITS(NUM_UNITS), .NUM_CHK(NUM_CHK), .ADDR_W(ADDR_W),
    .CPL_TIMEOUT(CPL_TIMEOUT), .SW_WAIT(SW_WAIT), .RST_CYC(RST_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .instrWord(instrWord),
    .rbLoad(rbLoad), .rbAddrIn(rbAddrIn),
    .unitComplete(unitComplete), .unitActive(unitActive), .unitFault(unitFault),
    .chkErr(chkErr), .swStatus(swStatus),
    .dpFault(dpFault), .dpRepeat(dpRepeat), .dpDone(dpDone),
    .swChanged(swChanged), .swExpired(swExpired), .rstExpired(rstExpired),
    .syncOut(syncOut), .swToggle(swToggle), .rollAddr(rollAddr),
    .replaceFail(replaceFail)
  );

  assign unitRst = {NUM_UNITS{rstAll}};

  // R7
  roll_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    rollbackReq |-> (&unitRst));

  // R11
  fail_with_roll_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(replaceFail) |-> rollbackReq);

  // R13
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && instrValid) |=> (syncOut == '0));

endmodule

// File: tb/sim_rbc_top.sv
`timescale 1ns/1ps
module sim_rbc_top;
  localparam int N    = 4;
  localparam int NC   = 2;
  localparam int AW   = 12;
  localparam int TOUT = 12;
  localparam int SWW  = 6;
  localparam int RSTC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instrValid = 1'b0;
  logic [2*N-1:0] instrWord = '0;
  logic ready;
  logic rbLoad = 1'b0;
  logic [AW-1:0] rbAddrIn = '0;
  logic powerGlitch = 1'b0;
  logic [N-1:0] unitComplete = '0, unitActive = '0, unitFault = '0;
  logic [NC-1:0] chkErr = '0;
  logic [N-1:0] swStatus = '0;
  logic [N-1:0] syncOut, unitRst, swToggle;
  logic rollbackReq, instrDone, replaceFail;
  logic [AW-1:0] rollAddr;

  logic stuckSw = 1'b0;
  logic monOn = 1'b0;
  logic finished = 1'b0;
  int nChecks = 0;
  int nFails = 0;
  logic [AW-1:0] curRb;

  typedef struct { int kind; int val; } ev_t; // 0 sync, 1 done, 2 roll, 3 toggle
  ev_t expQ[$];

  always #2.5 clk = ~clk;

  rbc_top #(.NUM_UNITS(N), .NUM_CHK(NC), .ADDR_W(AW), .CPL_TIMEOUT(TOUT),
            .SW_WAIT(SWW), .RST_CYC(RSTC)) u0 (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .ready(ready), .rbLoad(rbLoad), .rbAddrIn(rbAddrIn), .powerGlitch(powerGlitch),
    .unitComplete(unitComplete), .unitActive(unitActive), .unitFault(unitFault),
    .chkErr(chkErr), .swStatus(swStatus), .syncOut(syncOut), .unitRst(unitRst),
    .swToggle(swToggle), .rollbackReq(rollbackReq), .rollAddr(rollAddr),
    .instrDone(instrDone), .replaceFail(replaceFail)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input int k, input int v);
    ev_t e;
    e.kind = k; e.val = v;
    expQ.push_back(e);
  endtask

  task automatic observe(input int k, input int v, input string req);
    ev_t e;
    if (expQ.size() == 0) begin
      check(1'b0, req, (k << 16) | v, -1);
    end else begin
      e = expQ.pop_front();
      check(e.kind == k && e.val == v, req, (k << 16) | v, (e.kind << 16) | e.val);
    end
  endtask

  // monitor: pops the expected event list as the design emits events
  always @(negedge clk) begin
    if (monOn) begin
      if (syncOut != '0) observe(0, int'(syncOut), "R2");
      if (instrDone)     observe(1, 1, "R3");
      if (rollbackReq) begin
        observe(2, int'(rollAddr), "R7");
        check(unitRst == '1, "R7 reset on rollback", int'(unitRst), 'hF);
      end
      if (swToggle != '0) observe(3, int'(swToggle), "R9");
    end
  end

  // power-switch model: flips status on a toggle unless stuck
  always @(negedge clk) begin
    if (!stuckSw) swStatus <= swStatus ^ swToggle;
  end

  task automatic issue(input logic [N-1:0] act, input logic [N-1:0] cpl);
    while (!ready) @(negedge clk);
    instrWord = {act, cpl};
    instrValid = 1'b1;
    push(0, int'(cpl));
    @(negedge clk);
    instrValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (!ready) @(negedge clk);
  endtask

  task automatic cleanRun(input logic [N-1:0] m);
    issue(m, m);
    unitComplete = m; unitActive = m;
    push(1, 1);
    @(negedge clk);
    unitComplete = '0; unitActive = '0;
    waitIdle();
  endtask

  task automatic faultRun(input logic [N-1:0] act, input logic [N-1:0] cpl,
                          input logic [N-1:0] flt, input logic [NC-1:0] chk,
                          input logic [N-1:0] xact, input logic [N-1:0] xcpl,
                          input logic [N-1:0] togMask);
    issue(act, cpl);
    unitFault = flt; chkErr = chk; unitActive = xact; unitComplete = xcpl;
    if (togMask != '0) push(3, int'(togMask));
    push(2, int'(curRb));
    @(negedge clk);
    unitFault = '0; chkErr = '0; unitActive = '0; unitComplete = '0;
    waitIdle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ready == 1'b1, "R1 ready", int'(ready), 1);
    check({syncOut, unitRst, swToggle} == '0, "R1 unit outputs",
          int'({syncOut, unitRst, swToggle}), 0);
    check({rollbackReq, instrDone, replaceFail} == '0, "R1 flags",
          int'({rollbackReq, instrDone, replaceFail}), 0);
    monOn = 1'b1;

    // R8 load rollback point
    rbLoad = 1'b1; rbAddrIn = 12'h123; curRb = 12'h123;
    @(negedge clk);
    rbLoad = 1'b0;
    check(rollAddr == 12'h123, "R8", int'(rollAddr), 'h123);

    // R2 R3 clean instruction, all at once
    cleanRun(4'b0011);

    // R3 completion spread over cycles in reverse order
    issue(4'b0110, 4'b0110);
    unitComplete = 4'b0100;
    @(negedge clk);
    check(instrDone == 1'b0, "R3 partial", int'(instrDone), 0);
    unitComplete = 4'b0010;
    push(1, 1);
    @(negedge clk);
    unitComplete = '0;
    waitIdle();

    // R4 illegal Active on unit 2 -> rollback, flag set (R7)
    faultRun(4'b0001, 4'b0001, '0, '0, 4'b0100, '0, '0);
    // R9 internal fault on unit 2 again -> toggle then rollback
    faultRun(4'b0001, 4'b0001, 4'b0100, '0, '0, '0, 4'b0100);
    check(swStatus[2] == 1'b1, "R9 switch moved", int'(swStatus[2]), 1);
    // replaced unit starts fresh: rollback only
    faultRun(4'b0001, 4'b0001, 4'b0100, '0, '0, '0, '0);
    // R10 clean completion clears the flag
    cleanRun(4'b0001);
    faultRun(4'b0001, 4'b0001, 4'b0100, '0, '0, '0, '0);
    cleanRun(4'b0001);

    // R6 timeout on unit 3
    stuckSw = 1'b1;
    issue(4'b0000, 4'b1000);
    push(2, int'(curRb));
    n = 0;
    while (!rollbackReq) begin
      @(negedge clk);
      n++;
    end
    check(n == TOUT, "R6 timeout length", n, TOUT);
    waitIdle();
    check(replaceFail == 1'b0, "R11 not yet", int'(replaceFail), 0);
    // R11 second timeout -> toggle on stuck switch -> fail, still rollback
    issue(4'b0000, 4'b1000);
    push(3, 4'b1000);
    push(2, int'(curRb));
    waitIdle();
    check(replaceFail == 1'b1, "R11 set", int'(replaceFail), 1);
    stuckSw = 1'b0;
    cleanRun(4'b0001);

    // R5 checker error charged to lowest Active unit (unit 1 of 0110)
    faultRun(4'b0110, 4'b0010, '0, 2'b01, '0, '0, '0);
    faultRun(4'b0110, 4'b0010, '0, 2'b10, '0, '0, 4'b0010);
    check(replaceFail == 1'b1, "R11 sticky", int'(replaceFail), 1);
    // R5 empty Active mask: never replaced
    faultRun(4'b0000, 4'b0001, '0, 2'b01, '0, '0, '0);
    faultRun(4'b0000, 4'b0001, '0, 2'b01, '0, '0, '0);

    // R4 illegal Complete from unit 1, plus expected Complete: fault wins
    faultRun(4'b0000, 4'b0001, '0, '0, '0, 4'b0011, '0);

    // R12 restart: reset held RSTC cycles then rollback
    powerGlitch = 1'b1;
    push(2, int'(curRb));
    @(negedge clk);
    powerGlitch = 1'b0;
    n = 0;
    while (unitRst == '1) begin
      n++;
      @(negedge clk);
    end
    check(n == RSTC + 1, "R12 reset length", n, RSTC + 1);
    waitIdle();
    // R12 flags cleared: unit 1 faults again, rollback only
    faultRun(4'b0001, 4'b0001, 4'b0010, '0, '0, '0, '0);
    cleanRun(4'b0001);

    // R13 instruction offered while busy is ignored
    issue(4'b0001, 4'b0001);
    check(ready == 1'b0, "R13 busy", int'(ready), 0);
    instrValid = 1'b1; instrWord = {4'b0000, 4'b1000};
    @(negedge clk);
    instrValid = 1'b0;
    unitComplete = 4'b0001;
    push(1, 1);
    @(negedge clk);
    unitComplete = '0;
    waitIdle();
    repeat (3) @(negedge clk);
    check(syncOut == '0, "R13 no extra sync", int'(syncOut), 0);

    // R8 new rollback point used on the next rollback
    rbLoad = 1'b1; rbAddrIn = 12'h0AB; curRb = 12'h0AB;
    @(negedge clk);
    rbLoad = 1'b0;
    check(rollAddr == 12'h0AB, "R8 reload", int'(rollAddr), 'h0AB);
    faultRun(4'b0001, 4'b0001, 4'b0001, '0, '0, '0, '0);

    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R7 pending events", expQ.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule